// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block is a register-mapped controller for a byte-addressed one-time-programmable array. Software writes a byte address, picks a read or a program command and starts it with a GO bit. It then polls a status register until the operation is done, and finally checks the pass/fail flags or collects the byte that was read. The array is kept powered down after reset. When software powers it up, it must wait while an internal pump settle phase runs; a command started before that phase ends is ignored.

Programming can only set bits: the stored byte becomes the old byte ORed with the program data, so a bit that is already set never clears. Two parameterised address windows guard the array. Reads in the read-guarded window and programs in the write-guarded window do not touch the array and raise their own flag instead. A program also needs byte mode to be enabled; without it the operation fails. The array is modelled as a register store, indexed by the low `STORE_W` bits of the 13-bit byte address.

Top module: `otp_regif`

## Requirements
- R1: After reset the power control register (offset 0x00) reads 1, which means powered down. Every other register reads 0: status, pass/fail, GO, read data, address, program data, mode and command.
- R2: Register reads return the stored values. Address-high (0x04) keeps only bits 4:0, because the byte address is 13 bits. Address-low (0x08) and program data (0x10) keep 8 bits, mode (0x14) keeps bit 0 and command (0x20) keeps bits 1:0. Any offset that is not mapped reads as 0.
- R3: Writing 0 to bit 0 of 0x00 while powered down sets status bit 1 (pump settling) for exactly SETTLE cycles. Writing 1 powers the array down and clears that bit.
- R4: A write of 1 to GO (0x28, bit 0) is ignored, so GO reads 0 and busy stays low, in any of these cases: the array is powered down, the pump is settling, a command is busy, or command bits 1:0 are 00.
- R5: An accepted GO reads 1 for one cycle. Status bit 0 (busy) then reads 1 for exactly RD_LAT cycles for a read, or PG_LAT cycles for a program.
- R6: A completed read (command bit 0) puts the addressed byte in bits 7:0 of read data (0x18). Bits 31:8 read 0.
- R7: A completed program (command bit 1, mode bit 0 set) stores the OR of the old byte and the program data.
- R8: A read whose address lies in [RDP_LO, RDP_HI] sets pass/fail bit 3 and leaves read data unchanged.
- R9: A program whose address lies in [WRP_LO, WRP_HI] sets pass/fail bit 2 and leaves the array unchanged.
- R10: A program with mode bit 0 clear, outside the write-guarded window, sets pass/fail bit 0 and leaves the array unchanged.
- R11: All pass/fail flags clear when the next command is accepted. At most one flag is set at any time.
- R12: Command value 11 runs a read. Address, data and mode are captured when the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 10 | Byte offset within the 0x300 register window |
| reg_wr | input | 1 | Write strobe for the current offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current offset (combinational) |

## Verification
The assertions check the following on every cycle:
- GO only rises after a cycle in which the array was powered, settled and idle.
- GO lasts one cycle and hands over to busy.
- Busy runs exactly the latency of the captured command.
- Flags clear on acceptance and stay one-hot.
- The pump is only active while powered.
- Every array update only sets bits.

The bench's scenarios show the parts the assertions cannot cover. These are the data path (which byte comes back after a chain of ORed programs), the exact pump and busy lengths seen at the register port, the guarded windows and the byte-mode failure leaving contents untouched, and the ignored-GO cases.

// File: rtl/otp_regif_pkg.sv
package otp_regif_pkg;

  localparam logic [9:0] OFS_PWR    = 10'h000;
  localparam logic [9:0] OFS_ADDRHI = 10'h004;
  localparam logic [9:0] OFS_ADDRLO = 10'h008;
  localparam logic [9:0] OFS_PDATA  = 10'h010;
  localparam logic [9:0] OFS_PMODE  = 10'h014;
  localparam logic [9:0] OFS_RDATA  = 10'h018;
  localparam logic [9:0] OFS_CMD    = 10'h020;
  localparam logic [9:0] OFS_GO     = 10'h028;
  localparam logic [9:0] OFS_PF     = 10'h02C;
  localparam logic [9:0] OFS_STAT   = 10'h030;

  typedef struct packed {
    logic rd_prot;
    logic wr_prot;
    logic pg_fail;
  } otp_flags_t;

  // inclusive window test on a byte address
  function automatic logic in_window(input logic [15:0] a,
                                     input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // one-time-programmable cells can only go from 0 to 1
  function automatic logic [7:0] fuse_merge(input logic [7:0] old_b,
                                            input logic [7:0] new_b);
    return old_b | new_b;
  endfunction

  function automatic logic [31:0] pack_flags(input otp_flags_t f);
    return {28'd0, f.rd_prot, f.wr_prot, 1'b0, f.pg_fail};
  endfunction

endpackage

// File: rtl/otp_pump_seq.sv
module otp_pump_seq #(
  parameter int SETTLE = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_wr,
  input  logic pwr_bit,
  output logic pwrdn,
  output logic pump_act,
  output logic array_ready
);

  localparam int PW = $clog2(SETTLE + 1);

  logic [PW-1:0] pcnt;
  logic          power_up_ev;

  assign power_up_ev = pwr_wr && !pwr_bit && pwrdn;
  assign array_ready = !pwrdn && !pump_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwrdn    <= 1'b1;
      pump_act <= 1'b0;
      pcnt     <= '0;
    end else begin
      if (pwr_wr) pwrdn <= pwr_bit;
      if (pwr_wr && pwr_bit) begin
        pump_act <= 1'b0;
        pcnt     <= '0;
      end else if (power_up_ev) begin
        pump_act <= 1'b1;
        pcnt     <= PW'(SETTLE - 1);
      end else if (pump_act) begin
        if (pcnt == '0) pump_act <= 1'b0;
        else            pcnt     <= pcnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store #(
  parameter int STORE_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STORE_W-1:0] idx,
  output logic [7:0]         rbyte,
  input  logic               pg_en,
  input  logic [7:0]         pg_byte
);

  localparam int DEPTH = 1 << STORE_W;

  logic [7:0] cells [DEPTH];

  assign rbyte = cells[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (pg_en) begin
      cells[idx] <= pg_byte;
    end
  end

endmodule

// File: rtl/otp_cmd_engine.sv
module otp_cmd_engine
  import otp_regif_pkg::*;
#(
  parameter int          ADDR_W  = 13,
  parameter int          STORE_W = 10,
  parameter int          RD_LAT  = 4,
  parameter int          PG_LAT  = 20,
  parameter logic [15:0] RDP_LO  = 16'h0100,
  parameter logic [15:0] RDP_HI  = 16'h010F,
  parameter logic [15:0] WRP_LO  = 16'h0000,
  parameter logic [15:0] WRP_HI  = 16'h003F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_req,
  input  logic               array_ready,
  input  logic [1:0]         cmd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         pdata,
  input  logic               byte_mode,
  input  logic [7:0]         st_rbyte,
  output logic               go_q,
  output logic               busy,
  output otp_flags_t         flags,
  output logic [7:0]         rd_byte,
  output logic [STORE_W-1:0] st_idx,
  output logic               pg_en,
  output logic [7:0]         pg_byte,
  output logic               accept_ev,
  output logic               done_ev,
  output logic               op_rd
);

  localparam int MAXL = (RD_LAT > PG_LAT) ? RD_LAT : PG_LAT;
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data;
  logic              op_mode;
  logic              go_ok;
  logic              rd_blocked;
  logic              wr_blocked;

  assign go_ok      = go_req && array_ready && !busy && !go_q && (cmd != 2'b00);
  assign accept_ev  = go_q;
  assign done_ev    = busy && (cnt == '0);
  assign rd_blocked = in_window(16'(op_addr), RDP_LO, RDP_HI);
  assign wr_blocked = in_window(16'(op_addr), WRP_LO, WRP_HI);
  assign st_idx     = op_addr[STORE_W-1:0];
  assign pg_byte    = fuse_merge(st_rbyte, op_data);
  assign pg_en      = done_ev && !op_rd && !wr_blocked && op_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      flags   <= '0;
      rd_byte <= 8'h00;
      op_rd   <= 1'b0;
      op_addr <= '0;
      op_data <= 8'h00;
      op_mode <= 1'b0;
    end else begin
      go_q <= go_q ? 1'b0 : go_ok;
      if (accept_ev) begin
        busy    <= 1'b1;
        cnt     <= cmd[0] ? CW'(RD_LAT - 1) : CW'(PG_LAT - 1);
        flags   <= '0;
        op_rd   <= cmd[0];
        op_addr <= addr;
        op_data <= pdata;
        op_mode <= byte_mode;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          if (op_rd) begin
            if (rd_blocked) flags.rd_prot <= 1'b1;
            else            rd_byte       <= st_rbyte;
          end else begin
            if (wr_blocked)    flags.wr_prot <= 1'b1;
            else if (!op_mode) flags.pg_fail <= 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/otp_regif.sv
module otp_regif
  import otp_regif_pkg::*;
#(
  parameter int          ADDR_W  = 13,
  parameter int          STORE_W = 10,
  parameter int          SETTLE  = 6,
  parameter int          RD_LAT  = 4,
  parameter int          PG_LAT  = 20,
  parameter logic [15:0] RDP_LO  = 16'h0100,
  parameter logic [15:0] RDP_HI  = 16'h010F,
  parameter logic [15:0] WRP_LO  = 16'h0000,
  parameter logic [15:0] WRP_HI  = 16'h003F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);

  localparam logic [7:0] HI_MASK = 8'((1 << (ADDR_W - 8)) - 1);

  logic [7:0]         addr_hi;
  logic [7:0]         addr_lo;
  logic [7:0]         pdata;
  logic               pmode;
  logic [1:0]         cmd;
  logic [ADDR_W-1:0]  full_addr;

  logic               pwrdn;
  logic               pump_act;
  logic               array_ready;
  logic               go_q;
  logic               busy;
  otp_flags_t         flags;
  logic [7:0]         rd_byte;
  logic [STORE_W-1:0] st_idx;
  logic [7:0]         st_rbyte;
  logic               pg_en;
  logic [7:0]         pg_byte;
  logic               accept_ev;
  logic               done_ev;
  logic               op_rd;

  logic               wr_pwr;
  logic               go_req;

  assign wr_pwr    = reg_wr && (reg_addr == OFS_PWR);
  assign go_req    = reg_wr && (reg_addr == OFS_GO) && reg_wdata[0];
  assign full_addr = ADDR_W'({addr_hi, addr_lo});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_hi <= 8'h00;
      addr_lo <= 8'h00;
      pdata   <= 8'h00;
      pmode   <= 1'b0;
      cmd     <= 2'b00;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_ADDRHI: addr_hi <= reg_wdata[7:0] & HI_MASK;
        OFS_ADDRLO: addr_lo <= reg_wdata[7:0];
        OFS_PDATA:  pdata   <= reg_wdata[7:0];
        OFS_PMODE:  pmode   <= reg_wdata[0];
        OFS_CMD:    cmd     <= reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_PWR:    reg_rdata = {31'd0, pwrdn};
      OFS_ADDRHI: reg_rdata = {24'd0, addr_hi};
      OFS_ADDRLO: reg_rdata = {24'd0, addr_lo};
      OFS_PDATA:  reg_rdata = {24'd0, pdata};
      OFS_PMODE:  reg_rdata = {31'd0, pmode};
      OFS_RDATA:  reg_rdata = {24'd0, rd_byte};
      OFS_CMD:    reg_rdata = {30'd0, cmd};
      OFS_GO:     reg_rdata = {31'd0, go_q};
      OFS_PF:     reg_rdata = pack_flags(flags);
      OFS_STAT:   reg_rdata = {30'd0, pump_act, busy};
      default:    reg_rdata = 32'd0;
    endcase
  end

  otp_pump_seq #(
    .SETTLE(SETTLE)
  ) u_pump (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_wr      (wr_pwr),
    .pwr_bit     (reg_wdata[0]),
    .pwrdn       (pwrdn),
    .pump_act    (pump_act),
    .array_ready (array_ready)
  );

  otp_cmd_engine #(
    .ADDR_W (ADDR_W),
    .STORE_W(STORE_W),
    .RD_LAT (RD_LAT),
    .PG_LAT (PG_LAT),
    .RDP_LO (RDP_LO),
    .RDP_HI (RDP_HI),
    .WRP_LO (WRP_LO),
    .WRP_HI (WRP_HI)
  ) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_req      (go_req),
    .array_ready (array_ready),
    .cmd         (cmd),
    .addr        (full_addr),
    .pdata       (pdata),
    .byte_mode   (pmode),
    .st_rbyte    (st_rbyte),
    .go_q        (go_q),
    .busy        (busy),
    .flags       (flags),
    .rd_byte     (rd_byte),
    .st_idx      (st_idx),
    .pg_en       (pg_en),
    .pg_byte     (pg_byte),
    .accept_ev   (accept_ev),
    .done_ev     (done_ev),
    .op_rd       (op_rd)
  );

  otp_fuse_store #(
    .STORE_W(STORE_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (st_idx),
    .rbyte   (st_rbyte),
    .pg_en   (pg_en),
    .pg_byte (pg_byte)
  );

endmodule

// File: rtl/otp_regif_chk.sv
module otp_regif_chk
  import otp_regif_pkg::*;
#(
  parameter int RD_LAT = 4,
  parameter int PG_LAT = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwrdn,
  input logic       pump_act,
  input logic       go_q,
  input logic       busy,
  input logic       accept_ev,
  input logic       done_ev,
  input logic       op_rd,
  input otp_flags_t flags,
  input logic       pg_en,
  input logic [7:0] pg_byte,
  input logic [7:0] st_rbyte
);

  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  a_r4_go_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !$past(go_q)) |-> $past(!pwrdn && !pump_act && !busy));

  a_r5_go_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> (!go_q && busy));

  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (int'(run) == (op_rd ? RD_LAT : PG_LAT)));

  a_r3_pump_only_powered: assert property (@(posedge clk) disable iff (!rst_n)
    pump_act |-> !pwrdn);

  a_r11_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (flags == '0));

  a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flags.rd_prot, flags.wr_prot, flags.pg_fail}));

  a_r7_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    pg_en |-> (((pg_byte & st_rbyte) == st_rbyte) && done_ev && !op_rd));

endmodule

bind otp_regif otp_regif_chk #(
  .RD_LAT(RD_LAT),
  .PG_LAT(PG_LAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwrdn     (pwrdn),
  .pump_act  (pump_act),
  .go_q      (go_q),
  .busy      (busy),
  .accept_ev (accept_ev),
  .done_ev   (done_ev),
  .op_rd     (op_rd),
  .flags     (flags),
  .pg_en     (pg_en),
  .pg_byte   (pg_byte),
  .st_rbyte  (st_rbyte)
);

// File: tb/otp_regif_bench.sv
`timescale 1ns/1ps
module otp_regif_bench;

  localparam int SETTLE = 6;
  localparam int RD_LAT = 4;
  localparam int PG_LAT = 20;
  localparam int STORE  = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  otp_regif #(
    .SETTLE(SETTLE), .RD_LAT(RD_LAT), .PG_LAT(PG_LAT)
  ) u_otp_regif (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // ---------------- behavioural reference model ----------------
  int m_pd, m_pump, m_pcnt, m_go, m_busy, m_cnt, m_flags, m_rd;
  int m_hi, m_lo, m_pdat, m_mode, m_cmd;
  int o_rd, o_addr, o_data, o_mode;
  byte unsigned mem [int];

  function automatic int mget(int a);
    int k = a % STORE;
    return mem.exists(k) ? int'(mem[k]) : 0;
  endfunction

  task automatic m_reset();
    m_pd = 1; m_pump = 0; m_pcnt = 0; m_go = 0; m_busy = 0; m_cnt = 0;
    m_flags = 0; m_rd = 0; m_hi = 0; m_lo = 0; m_pdat = 0; m_mode = 0; m_cmd = 0;
    o_rd = 0; o_addr = 0; o_data = 0; o_mode = 0;
    mem.delete();
  endtask

  task automatic m_step(int a, int we, int d);
    int go_set;
    go_set = (we && a == 'h28 && (d & 1) && !m_pd && !m_pump && !m_busy
              && !m_go && m_cmd != 0) ? 1 : 0;
    if (m_go) begin
      m_busy = 1; m_cnt = (m_cmd & 1) ? RD_LAT : PG_LAT; m_flags = 0;
      o_rd = m_cmd & 1; o_addr = m_hi * 256 + m_lo; o_data = m_pdat; o_mode = m_mode;
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0;
        if (o_rd) begin
          if (o_addr >= 'h100 && o_addr <= 'h10F) m_flags = 8;
          else m_rd = mget(o_addr);
        end else begin
          if (o_addr <= 'h3F) m_flags = 4;
          else if (!o_mode) m_flags = 1;
          else mem[o_addr % STORE] = byte'(mget(o_addr) | o_data);
        end
      end
    end
    m_go = go_set;
    if (we && a == 0) begin
      if (d & 1) begin m_pump = 0; m_pcnt = 0; end
      else if (m_pd) begin m_pump = 1; m_pcnt = SETTLE; end
      else if (m_pump) begin m_pcnt--; if (m_pcnt == 0) m_pump = 0; end
      m_pd = d & 1;
    end else if (m_pump) begin
      m_pcnt--; if (m_pcnt == 0) m_pump = 0;
    end
    if (we) begin
      case (a)
        'h04: m_hi = d & 'h1F;
        'h08: m_lo = d & 'hFF;
        'h10: m_pdat = d & 'hFF;
        'h14: m_mode = d & 1;
        'h20: m_cmd = d & 3;
        default: ;
      endcase
    end
  endtask

  function automatic int m_read(int a);
    case (a)
      'h00: return m_pd;
      'h04: return m_hi;
      'h08: return m_lo;
      'h10: return m_pdat;
      'h14: return m_mode;
      'h18: return m_rd;
      'h20: return m_cmd;
      'h28: return m_go;
      'h2C: return m_flags;
      'h30: return m_pump * 2 + m_busy;
      default: return 0;
    endcase
  endfunction

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step(int'(reg_addr), int'(reg_wr), int'(reg_wdata));
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      #2;
      chk((reg_addr == 10'h30) ? "R5 model" : (reg_addr == 10'h2C) ? "R11 model" :
          (reg_addr == 10'h18) ? "R6 model" : "R2 model",
          int'(reg_rdata), m_read(int'(reg_addr)));
    end
  end

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      summary();
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_addr = 10'(a); reg_wdata = 32'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(int a, int exp, string tag);
    reg_addr = 10'(a);
    #3;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic set_op(int addr, int cmd, int data, int mode);
    wr('h04, addr >> 8); wr('h08, addr & 'hFF);
    wr('h10, data); wr('h14, mode); wr('h20, cmd);
  endtask

  task automatic run_cmd(int exp_lat, string tag);
    int n = 0;
    wr('h28, 1);
    peek('h28, 1, "R5 go visible");
    @(negedge clk);
    reg_addr = 10'h30;
    #1;
    while ((reg_rdata[0]) && n < 1000) begin
      n++;
      @(negedge clk);
      #1;
    end
    chk(tag, n, exp_lat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek('h00, 1, "R1 pwrdn"); peek('h30, 0, "R1 status");
    peek('h2C, 0, "R1 passfail"); peek('h18, 0, "R1 rdata");
    peek('h28, 0, "R1 go"); peek('h20, 0, "R1 cmd");
    // R2 readback and widths
    wr('h04, 'hFF); peek('h04, 'h1F, "R2 addr hi mask");
    wr('h08, 'h1AB); peek('h08, 'hAB, "R2 addr lo mask");
    wr('h20, 'h7); peek('h20, 3, "R2 cmd mask");
    peek('h0C, 0, "R2 unmapped"); peek('h2FC, 0, "R2 unmapped hi");
    // R4 GO while powered down
    wr('h20, 1); wr('h28, 1); peek('h28, 0, "R4 go while down");
    @(negedge clk); peek('h30, 0, "R4 no busy while down");
    // R4 GO during pump settle
    wr('h00, 0); wr('h28, 1); peek('h28, 0, "R4 go while settling");
    repeat (10) @(negedge clk);
    // R3 settle length, measured on a second power-up
    wr('h00, 1); peek('h30, 0, "R3 pump off when down");
    wr('h00, 0);
    begin
      int n = 0;
      reg_addr = 10'h30; #1;
      while (reg_rdata[1] && n < 1000) begin n++; @(negedge clk); #1; end
      chk("R3 settle cycles", n, SETTLE);
    end
    // R4 no command selected
    wr('h20, 0); wr('h28, 1); peek('h28, 0, "R4 go with cmd 00");
    // R7 program then R6 read
    set_op('h055, 2, 'h5A, 1); run_cmd(PG_LAT, "R5 program busy length");
    peek('h2C, 0, "R7 program pass");
    set_op('h055, 1, 0, 1); run_cmd(RD_LAT, "R5 read busy length");
    peek('h18, 'h5A, "R6 read byte");
    set_op('h055, 2, 'h81, 1); run_cmd(PG_LAT, "R7 second program");
    set_op('h055, 1, 0, 1); run_cmd(RD_LAT, "R6 read length");
    peek('h18, 'hDB, "R7 or merge");
    // R8 read guard
    set_op('h105, 1, 0, 1); run_cmd(RD_LAT, "R8 guarded read length");
    peek('h2C, 8, "R8 read flag"); peek('h18, 'hDB, "R8 rdata kept");
    // R11 flags clear on next command
    set_op('h055, 1, 0, 1); wr('h28, 1); @(negedge clk);
    peek('h2C, 0, "R11 flags cleared");
    begin
      // R4 GO while busy is ignored
      wr('h28, 1); peek('h28, 0, "R4 go while busy");
    end
    repeat (RD_LAT + 2) @(negedge clk);
    // R9 write guard
    set_op('h010, 2, 'hFF, 1); run_cmd(PG_LAT, "R9 guarded program length");
    peek('h2C, 4, "R9 write flag");
    set_op('h010, 1, 0, 1); run_cmd(RD_LAT, "R9 readback len");
    peek('h18, 0, "R9 array unchanged");
    // R10 byte mode off
    set_op('h060, 2, 'h3C, 0); run_cmd(PG_LAT, "R10 program length");
    peek('h2C, 1, "R10 fail flag");
    set_op('h060, 1, 0, 1); run_cmd(RD_LAT, "R10 readback len");
    peek('h18, 0, "R10 array unchanged");
    // R12 cmd 11 is a read
    set_op('h055, 3, 'hFF, 1); run_cmd(RD_LAT, "R12 cmd 11 read length");
    peek('h18, 'hDB, "R12 read data");
    // R12 capture at accept: change address right after GO
    set_op('h055, 1, 0, 1); wr('h28, 1); wr('h08, 'h60);
    repeat (RD_LAT + 2) @(negedge clk);
    peek('h18, 'hDB, "R12 address captured");
    // R3 power down clears everything pending
    wr('h00, 1); peek('h00, 1, "R3 powered down");
    repeat (3) @(negedge clk);
    summary();
  end

endmodule